// File: doc/BRIEF.md
# Soft-Ramp Zero-Cross Volume Controller

This block applies a digital attenuation to one channel of signed PCM audio. A new 8-bit attenuation code, or a mute request, does not jump straight onto the signal. The block moves an internal level toward the requested target under one of four change policies, selected per call by a 2-bit mode input. Each accepted sample is multiplied by the linear gain that the current level maps to. Each channel of a multichannel converter gets its own instance, so every channel watches its own zero crossings.

The level is kept in 1/8 dB units. An attenuation code counts half-decibels. The linear gain is formed from a right shift of one bit per 6 dB plus a 48-entry fractional gain table that covers the remainder within the octave. All level movement happens on sample strobes. The strobe that moves the level is also the first sample scaled at the new level. A sample is treated as a zero crossing when its sign differs from the previous sample's, or when it is exactly zero. In the two zero-cross modes, a pending change that finds no crossing is forced through after a bounded number of samples.

Top module: `vol_ramp_ctl`

## Requirements
- R1: After reset the level is full mute (1024 eighth-dB units), `muted` is 1 and `smp_out_valid` is 0.
- R2: The target level is 4 × `atten_code` eighth-dB units, so code 0 is unity gain. A code that is a multiple of 12 divides the sample exactly by 2^(code/12), using an arithmetic shift (floor).
- R3: With `chg_mode` = 00, the whole change is applied on the next strobe, and that strobe's sample already uses the new gain.
- R4: With `chg_mode` = 01, the whole change is applied on the first strobe whose sample is a zero crossing. The sample is a crossing when its sign bit differs from the previous sample's sign bit, or when it equals 0. Until then the old gain stays in use.
- R5: In modes 01 and 11, when a change is pending and 511 consecutive strobes have passed without a crossing, the 512th strobe takes the change or step anyway.
- R6: With `chg_mode` = 10, each strobe moves the level one 1/8 dB unit toward the target, and the level then stays at the target.
- R7: With `chg_mode` = 11, the level moves one 1/8 dB unit per crossing strobe, subject to the timeout in R5.
- R8: `mute_req` sets the target to full mute (1024) under the same mode policy. `muted` is 1 only when the level equals full mute, and the output samples are then 0.
- R9: Without a strobe the level does not change and `smp_out_valid` stays 0.
- R10: `smp_out` and `smp_out_valid` are registered and appear one clock after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| atten_code | input | 8 | Attenuation in 0.5 dB steps |
| mute_req | input | 1 | Request ramp/step to full mute |
| chg_mode | input | 2 | 00 immediate, 01 zero-cross, 10 ramp, 11 ramp on zero-cross |
| smp_valid | input | 1 | Sample strobe |
| smp_in | input | SMP_W | Signed input sample |
| smp_out | output | SMP_W | Signed attenuated sample |
| smp_out_valid | output | 1 | Output sample strobe |
| muted | output | 1 | Level has reached full mute |

## Verification
Two events can land on the same strobe: the timeout expiring and a real crossing arriving, or a step being taken and the output being scaled. The bench makes the scaling coincide with every step by reading each output sample right after its strobe. It then judges the step's timing by the sample on which the exact 6 dB output value first appears. It also holds a constant positive input so that no crossing occurs, which forces the timeout path. It then checks that the step shows up on the 512th sample and not on the 511th.

// File: rtl/vol_pkg.sv
package vol_pkg;
    localparam int LVL_W         = 11;
    localparam int MUTE_LVL      = 1024;
    localparam int STEPS_PER_OCT = 48;
    localparam int GAIN_W        = 16;
    localparam int GAIN_FRAC     = 15;
    localparam int SH_W          = 5;
    localparam int FR_W          = 6;
    localparam int STEP_MULT     = 32300;   // 10^(-1/160) in Q15

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [1:0] {
        CHG_IMMEDIATE = 2'b00,
        CHG_ZERO_X    = 2'b01,
        CHG_RAMP      = 2'b10,
        CHG_RAMP_ZX   = 2'b11
    } chg_mode_e;

    typedef struct packed {
        logic [SH_W-1:0] shift;
        logic [FR_W-1:0] frac;
    } gain_idx_t;

    function automatic logic [STEPS_PER_OCT*GAIN_W-1:0] build_gain_tab();
        logic [STEPS_PER_OCT*GAIN_W-1:0] tab;
        logic [31:0] g;
        tab = '0;
        g   = 32'd32768;
        for (int k = 0; k < STEPS_PER_OCT; k++) begin
            tab[k*GAIN_W +: GAIN_W] = g[GAIN_W-1:0];
            g = (g * STEP_MULT + 32'd16384) >> GAIN_FRAC;
        end
        return tab;
    endfunction

    function automatic lvl_t target_level(input logic [7:0] code, input logic mute);
        return mute ? lvl_t'(MUTE_LVL) : lvl_t'({code, 2'b00});
    endfunction
endpackage

// File: rtl/vol_zc_detect.sv
module vol_zc_detect
    import vol_pkg::*;
#(
    parameter int W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic signed [W-1:0] smp,
    output logic                zc
);
    logic prev_neg;

    always_comb begin
        zc = (smp == '0) || (smp[W-1] != prev_neg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_neg <= 1'b0;
        end else if (tick) begin
            prev_neg <= smp[W-1];
        end
    end
endmodule

// File: rtl/vol_step_ctrl.sv
module vol_step_ctrl
    import vol_pkg::*;
#(
    parameter int TMO = 512
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      zc,
    input  chg_mode_e mode,
    input  lvl_t      tgt,
    output lvl_t      lvl,
    output lvl_t      lvl_nxt
);
    localparam int CNT_W = $clog2(TMO);

    logic [CNT_W-1:0] wait_cnt;
    logic pending, tmo_hit, gate, zx_mode;
    lvl_t one_step;

    always_comb begin
        pending = (lvl != tgt);
        tmo_hit = (wait_cnt == CNT_W'(TMO - 1));
        gate    = zc || tmo_hit;
        zx_mode = (mode == CHG_ZERO_X) || (mode == CHG_RAMP_ZX);
        if (tgt > lvl)      one_step = lvl + lvl_t'(1);
        else if (tgt < lvl) one_step = lvl - lvl_t'(1);
        else                one_step = lvl;
        unique case (mode)
            CHG_IMMEDIATE: lvl_nxt = tgt;
            CHG_ZERO_X:    lvl_nxt = gate ? tgt : lvl;
            CHG_RAMP:      lvl_nxt = one_step;
            CHG_RAMP_ZX:   lvl_nxt = gate ? one_step : lvl;
            default:       lvl_nxt = lvl;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl      <= lvl_t'(MUTE_LVL);
            wait_cnt <= '0;
        end else if (tick) begin
            lvl <= lvl_nxt;
            if (!pending || !zx_mode || gate) wait_cnt <= '0;
            else                             wait_cnt <= wait_cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/vol_gain.sv
module vol_gain
    import vol_pkg::*;
#(
    parameter int W = 24
) (
    input  lvl_t                lvl,
    input  logic signed [W-1:0] smp,
    output logic signed [W-1:0] y
);
    localparam int PW = W + GAIN_W + 1;
    localparam logic [STEPS_PER_OCT*GAIN_W-1:0] GTAB = build_gain_tab();

    gain_idx_t              idx;
    logic [GAIN_W-1:0]      g;
    logic [5:0]             sh_amt;
    logic signed [PW-1:0]   prod;
    logic signed [PW-1:0]   scaled;

    always_comb begin
        idx.shift = SH_W'(lvl / lvl_t'(STEPS_PER_OCT));
        idx.frac  = FR_W'(lvl - lvl_t'(idx.shift * STEPS_PER_OCT));
        g         = GTAB[idx.frac * GAIN_W +: GAIN_W];
        sh_amt    = 6'(GAIN_FRAC) + 6'(idx.shift);
        prod      = PW'(smp) * PW'($signed({1'b0, g}));
        scaled    = prod >>> sh_amt;
        y         = (lvl >= lvl_t'(MUTE_LVL)) ? '0 : scaled[W-1:0];
    end
endmodule

// File: rtl/vol_ramp_ctl.sv
module vol_ramp_ctl
    import vol_pkg::*;
#(
    parameter int SMP_W      = 24,
    parameter int ZC_TIMEOUT = 512
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [7:0]              atten_code,
    input  logic                    mute_req,
    input  logic [1:0]              chg_mode,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_in,
    output logic signed [SMP_W-1:0] smp_out,
    output logic                    smp_out_valid,
    output logic                    muted
);
    lvl_t tgt_lvl, cur_lvl, nxt_lvl;
    logic zc;
    logic signed [SMP_W-1:0] scaled;

    assign tgt_lvl = target_level(atten_code, mute_req);

    vol_zc_detect #(.W(SMP_W)) u_zc (
        .clk(clk), .rst(rst), .tick(smp_valid), .smp(smp_in), .zc(zc)
    );

    vol_step_ctrl #(.TMO(ZC_TIMEOUT)) u_step (
        .clk(clk), .rst(rst), .tick(smp_valid), .zc(zc),
        .mode(chg_mode_e'(chg_mode)), .tgt(tgt_lvl),
        .lvl(cur_lvl), .lvl_nxt(nxt_lvl)
    );

    vol_gain #(.W(SMP_W)) u_gain (
        .lvl(nxt_lvl), .smp(smp_in), .y(scaled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_out       <= '0;
            smp_out_valid <= 1'b0;
        end else begin
            smp_out_valid <= smp_valid;
            if (smp_valid) smp_out <= scaled;
        end
    end

    assign muted = (cur_lvl == lvl_t'(MUTE_LVL));
endmodule

// File: rtl/vol_ramp_chk.sv
module vol_ramp_chk
    import vol_pkg::*;
#(
    parameter int W = 24
) (
    input logic                clk,
    input logic                rst,
    input logic [7:0]          atten_code,
    input logic                mute_req,
    input logic [1:0]          chg_mode,
    input logic                smp_valid,
    input logic signed [W-1:0] smp_out,
    input logic                smp_out_valid,
    input logic                muted,
    input lvl_t                lvl
);
    AST_IMMEDIATE_APPLY: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && chg_mode == 2'b00) |=> (lvl == target_level($past(atten_code), $past(mute_req)))); // R3
    AST_RAMP_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && chg_mode == 2'b10) |=> (lvl == $past(lvl) || lvl == $past(lvl) + lvl_t'(1) || lvl == $past(lvl) - lvl_t'(1))); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> ($stable(lvl) && !smp_out_valid)); // R9
    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> smp_out_valid); // R10
    AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (smp_out_valid && muted) |-> (smp_out == '0)); // R8
    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
        lvl <= lvl_t'(MUTE_LVL)); // R2
endmodule

bind vol_ramp_ctl vol_ramp_chk #(.W(SMP_W)) u_chk (
    .clk(clk), .rst(rst), .atten_code(atten_code), .mute_req(mute_req),
    .chg_mode(chg_mode), .smp_valid(smp_valid), .smp_out(smp_out),
    .smp_out_valid(smp_out_valid), .muted(muted), .lvl(cur_lvl)
);

// File: tb/tb_vol_ramp_ctl.sv
module tb_vol_ramp_ctl;
    localparam int W = 24;
    localparam int FULL = 1 << 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] atten_code = '0;
    logic mute_req = 1'b0;
    logic [1:0] chg_mode = 2'b00;
    logic smp_valid = 1'b0;
    logic signed [W-1:0] smp_in = '0;
    logic signed [W-1:0] smp_out;
    logic smp_out_valid, muted;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    vol_ramp_ctl #(.SMP_W(W), .ZC_TIMEOUT(512)) dut (
        .clk(clk), .rst(rst), .atten_code(atten_code), .mute_req(mute_req),
        .chg_mode(chg_mode), .smp_valid(smp_valid), .smp_in(smp_in),
        .smp_out(smp_out), .smp_out_valid(smp_out_valid), .muted(muted)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic signed [W-1:0] x, output logic signed [W-1:0] y);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_in    = x;
        @(negedge clk);
        smp_valid = 1'b0;
        y = smp_out;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic t_reset();
        check("R1 muted after reset", muted, 1);
        check("R1 out_valid after reset", smp_out_valid, 0);
    endtask

    task automatic t_immediate();
        logic signed [W-1:0] y;
        chg_mode = 2'b00; atten_code = 8'd0;
        send(24'sd1000, y);
        check("R3 unity immediate", y, 1000);
        check("R10 valid after strobe", smp_out_valid, 1);
        check("R8 not muted at unity", muted, 0);
        atten_code = 8'd12;
        send(24'sd1000, y);
        check("R2 code 12 halves", y, 500);
        atten_code = 8'd24;
        send(-24'sd1000, y);
        check("R2 code 24 quarter negative", y, -250);
    endtask

    task automatic t_idle();
        atten_code = 8'd0;
        repeat (4) @(negedge clk);
        check("R9 no valid without strobe", smp_out_valid, 0);
        check("R10 output held", smp_out, -250);
    endtask

    task automatic t_zero_cross();
        logic signed [W-1:0] y;
        chg_mode = 2'b01; atten_code = 8'd12;
        send(-24'sd800, y);
        check("R9 level kept over idle / R4 waits", y, -200);
        send(-24'sd400, y);
        check("R4 still waiting", y, -100);
        send(24'sd400, y);
        check("R4 applied on sign change", y, 200);
        atten_code = 8'd0;
        send(24'sd600, y);
        check("R4 no crossing keeps gain", y, 300);
        send(24'sd0, y);
        send(24'sd600, y);
        check("R4 zero sample is crossing", y, 600);
    endtask

    task automatic t_timeout();
        logic signed [W-1:0] y;
        chg_mode = 2'b01; atten_code = 8'd12;
        for (int k = 1; k <= 512; k++) begin
            send(24'sd1024, y);
            if (k == 511) check("R5 not yet at 511", y, 1024);
            if (k == 512) check("R5 forced at 512", y, 512);
        end
    endtask

    task automatic t_ramp();
        logic signed [W-1:0] y;
        logic signed [W-1:0] prev;
        logic mono;
        chg_mode = 2'b10; atten_code = 8'd0;
        prev = W'(FULL >> 1); mono = 1'b1;
        for (int k = 1; k <= 48; k++) begin
            send(W'(FULL), y);
            if (!(y > prev)) mono = 1'b0;
            prev = y;
            if (k == 47) check("R6 below unity at 47", y < W'(FULL), 1);
            if (k == 48) check("R6 unity at 48", y, FULL);
        end
        check("R6 rising each sample", mono, 1);
        atten_code = 8'd12; mono = 1'b1;
        for (int k = 1; k <= 49; k++) begin
            send(W'(FULL), y);
            if (!(y < prev) && k <= 48) mono = 1'b0;
            prev = y;
            if (k == 48) check("R6 half at 48", y, FULL >> 1);
            if (k == 49) check("R6 holds at target", y, FULL >> 1);
        end
        check("R6 falling each sample", mono, 1);
    endtask

    task automatic t_ramp_zc();
        logic signed [W-1:0] y;
        longint mag;
        chg_mode = 2'b11; atten_code = 8'd0;
        for (int k = 1; k <= 48; k++) begin
            send((k % 2 == 1) ? -W'(FULL) : W'(FULL), y);
            mag = (y < 0) ? -longint'(y) : longint'(y);
            if (k == 47) check("R7 one step per crossing at 47", mag < FULL, 1);
            if (k == 48) check("R7 target at 48 crossings", mag, FULL);
        end
        atten_code = 8'd12;
        for (int k = 1; k <= 512; k++) begin
            send(W'(FULL), y);
            if (k == 511) check("R7 no step without crossing", y, FULL);
            if (k == 512) check("R5 timeout step in ramp-zc", y < W'(FULL), 1);
        end
    endtask

    task automatic t_mute();
        logic signed [W-1:0] y;
        chg_mode = 2'b00; atten_code = 8'd0;
        send(W'(FULL), y);
        check("R3 back to unity", y, FULL);
        chg_mode = 2'b10; mute_req = 1'b1;
        for (int k = 1; k <= 1024; k++) begin
            send(W'(FULL), y);
            if (k == 1023) check("R8 not muted before full", muted, 0);
            if (k == 1024) begin
                check("R8 muted at full", muted, 1);
                check("R8 silent when muted", y, 0);
            end
        end
        mute_req = 1'b0; chg_mode = 2'b00;
        send(W'(FULL), y);
        check("R8 unmute immediate", y, FULL);
        check("R8 flag cleared", muted, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_immediate();
        t_idle();
        t_zero_cross();
        t_timeout();
        t_ramp();
        t_ramp_zc();
        t_mute();
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end
endmodule